// File: doc/BRIEF.md
# Write-Intensity Page-Type Predictor

This block learns which instructions produce many writebacks to memory and turns that knowledge into a page-placement hint. Each writeback event from the cache controller carries the program counter of the instruction that wrote the data. The block keeps a small direct-mapped table of such instruction addresses, with a saturating writeback count per entry.

When the allocator first touches a page, it queries the block with the PC of the touching instruction and a flag saying that this is the first touch. The block answers one cycle later. A set `resp_fast_write` means the page should be placed in fast-write memory. A clear `resp_fast_write` means fast-read memory. A single `clr` pulse forgets everything the table has learned.

Top module: `wip_predictor`

## Requirements
- R1: After reset every entry is invalid, `resp_valid` is 0 and a query to any PC answers fast-read.
- R2: `resp_valid` is 1 exactly in the cycle after a cycle with `q_valid` = 1. `resp_fast_write` is 0 whenever `resp_valid` is 0.
- R3: A writeback whose PC hits the table raises that entry's count by one. At the all-ones value of `CNT_W` bits the count saturates instead of wrapping.
- R4: A writeback whose PC misses, because the slot is empty or its tag differs, installs the PC in its slot with a count of exactly 1.
- R5: A query answers fast-write (`resp_fast_write` = 1) only when the PC hits, the entry's count is at least `THRESH`, and `q_first_touch` = 1.
- R6: A query whose PC misses the table answers fast-read (`resp_fast_write` = 0).
- R7: A query with `q_first_touch` = 0 answers fast-read, whatever the count.
- R8: `clr` invalidates every entry in one cycle. A writeback in the same cycle as `clr` is dropped.
- R9: A query in the same cycle as a writeback sees the table as it was before that writeback.
- R10: The slot index is PC bits [ALIGN+IDX_W-1:ALIGN] and the tag is the bits above them. Two PCs with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Invalidate the whole table |
| wb_valid | input | 1 | Writeback event this cycle |
| wb_pc | input | PC_W | PC of the instruction whose data was written back |
| q_valid | input | 1 | Query this cycle |
| q_pc | input | PC_W | PC of the instruction touching the page |
| q_first_touch | input | 1 | The query is for the first touch of a page |
| resp_valid | output | 1 | Response to the previous cycle's query |
| resp_fast_write | output | 1 | 1 = fast-write page, 0 = fast-read page |

## Verification
The bench builds the block with a 3-bit count and a threshold of 7, which is the saturation value. This lets one pass step through the threshold boundary at 6 and 7 writebacks. It also makes wrap-around visible: a counter that wraps after 9 further writebacks drops back below threshold and flips the answer to fast-read. The replacement rule that a new entry starts at 1 is pinned down because exactly 6 further writebacks are then needed to reach fast-write. Aliasing PCs that differ only above bit 5 exercise the tag compare and the eviction rule.

// File: rtl/wip_predictor.sv
module wip_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int ALIGN  = 2,
  parameter int CNT_W  = 8,
  parameter int THRESH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wb_valid,
  input  logic [PC_W-1:0] wb_pc,
  input  logic            q_valid,
  input  logic [PC_W-1:0] q_pc,
  input  logic            q_first_touch,
  output logic            resp_valid,
  output logic            resp_fast_write
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - ALIGN;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_TH  = CNT_W'(THRESH);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q [ENTRIES];

  logic [IDX_W-1:0] wb_idx, q_idx;
  logic [TAG_W-1:0] wb_tag, q_tag;
  logic             wb_hit, q_hit, do_wb;

  assign wb_idx = wb_pc[ALIGN +: IDX_W];
  assign wb_tag = wb_pc[PC_W-1 -: TAG_W];
  assign q_idx  = q_pc[ALIGN +: IDX_W];
  assign q_tag  = q_pc[PC_W-1 -: TAG_W];

  assign wb_hit = vld[wb_idx] && (tag_q[wb_idx] == wb_tag);
  assign q_hit  = vld[q_idx]  && (tag_q[q_idx]  == q_tag);
  assign do_wb  = wb_valid && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (clr) vld <= '0;
    else if (do_wb) vld[wb_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wb) begin
      if (!wb_hit) begin
        tag_q[wb_idx] <= wb_tag;
        cnt_q[wb_idx] <= CNT_W'(1);
      end else if (cnt_q[wb_idx] != CNT_MAX) begin
        cnt_q[wb_idx] <= cnt_q[wb_idx] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_fast_write <= 1'b0;
    end else begin
      resp_valid      <= q_valid;
      resp_fast_write <= q_valid && q_first_touch && q_hit && (cnt_q[q_idx] >= CNT_TH);
    end
  end

  p_resp_follows_query_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> resp_valid);
  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !resp_valid);
  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !resp_fast_write);
  p_fast_needs_touch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fast_write |-> $past(q_first_touch));
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));
  p_install_at_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wb && !wb_hit) |=> (cnt_q[$past(wb_idx)] == CNT_W'(1)));
  p_hit_increments_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wb && wb_hit && cnt_q[wb_idx] != CNT_MAX)
      |=> (cnt_q[$past(wb_idx)] == $past(cnt_q[wb_idx]) + CNT_W'(1)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wb && wb_hit && cnt_q[wb_idx] == CNT_MAX) |=> (cnt_q[$past(wb_idx)] == CNT_MAX));
endmodule

// File: tb/sim_wip_predictor.sv
module sim_wip_predictor;
  localparam int PC_W = 32;
  logic clk = 0, rst_n = 0, clr = 0, wb_valid = 0, q_valid = 0, q_first_touch = 0;
  logic [PC_W-1:0] wb_pc = '0, q_pc = '0;
  logic resp_valid, resp_fast_write;
  int checks = 0, failures = 0;

  localparam logic [PC_W-1:0] PC_A   = 32'h0040_0F94;
  localparam logic [PC_W-1:0] PC_B   = 32'h0040_1F94;
  localparam logic [PC_W-1:0] PC_C   = 32'h0040_1000;
  localparam logic [PC_W-1:0] PC_MIS = 32'h0050_0F94;

  always #4 clk = ~clk;

  wip_predictor #(.PC_W(PC_W), .IDX_W(4), .ALIGN(2), .CNT_W(3), .THRESH(7)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wb_valid(wb_valid), .wb_pc(wb_pc),
    .q_valid(q_valid), .q_pc(q_pc), .q_first_touch(q_first_touch),
    .resp_valid(resp_valid), .resp_fast_write(resp_fast_write));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wb(input logic [PC_W-1:0] pc, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wb_valid = 1; wb_pc = pc;
    end
    @(negedge clk); wb_valid = 0;
  endtask

  task automatic query(input string req, input logic [PC_W-1:0] pc, input logic ft, input logic exp);
    @(negedge clk); q_valid = 1; q_pc = pc; q_first_touch = ft;
    @(negedge clk); q_valid = 0; q_first_touch = 0;
    check({req, " valid"}, resp_valid, 1'b1);
    check(req, resp_fast_write, exp);
  endtask

  task automatic t_reset;
    check("R1 resp_valid in reset", resp_valid, 1'b0);
    @(negedge clk); rst_n = 1;
    query("R1 empty table", PC_C, 1'b1, 1'b0);
  endtask

  task automatic t_threshold;
    wb(PC_A, 6);
    query("R5 count 6 below", PC_A, 1'b1, 1'b0);
    wb(PC_A, 1);
    query("R5 count 7 at threshold", PC_A, 1'b1, 1'b1);
    query("R7 not first touch", PC_A, 1'b0, 1'b0);
    query("R6 tag miss", PC_MIS, 1'b1, 1'b0);
  endtask

  task automatic t_saturate;
    wb(PC_A, 9);
    query("R3 saturated count", PC_A, 1'b1, 1'b1);
  endtask

  task automatic t_alias;
    wb(PC_B, 1);
    query("R10 evicted alias", PC_A, 1'b1, 1'b0);
    query("R4 new entry at 1", PC_B, 1'b1, 1'b0);
    wb(PC_B, 5);
    query("R4 count 6 after install", PC_B, 1'b1, 1'b0);
    wb(PC_B, 1);
    query("R4 count 7 after install", PC_B, 1'b1, 1'b1);
  endtask

  task automatic t_concurrent;
    wb(PC_C, 6);
    @(negedge clk); wb_valid = 1; wb_pc = PC_C; q_valid = 1; q_pc = PC_C; q_first_touch = 1;
    @(negedge clk); wb_valid = 0; q_valid = 0; q_first_touch = 0;
    check("R9 pre-update view", resp_fast_write, 1'b0);
    query("R9 post-update view", PC_C, 1'b1, 1'b1);
  endtask

  task automatic t_clear;
    @(negedge clk); clr = 1; wb_valid = 1; wb_pc = PC_A;
    @(negedge clk); clr = 0; wb_valid = 0;
    query("R8 cleared entry", PC_B, 1'b1, 1'b0);
    query("R8 dropped writeback", PC_C, 1'b1, 1'b0);
    wb(PC_A, 6);
    query("R8 relearn count 6", PC_A, 1'b1, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R2 idle resp_valid", resp_valid, 1'b0);
    check("R2 idle resp_fast_write", resp_fast_write, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_threshold();
    t_saturate();
    t_alias();
    t_concurrent();
    t_clear();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule